// File: doc/BRIEF.md
# Thread Interrupt Context Priority Presenter

This block holds the interrupt state of one hardware thread for three privilege rings: an operating-system ring and two hypervisor rings, called POOL and PHYS. For each ring it keeps a pending-priority bitmap. It also keeps a group-enable size, a group backlog priority and a context-valid bit. It decides whether an arriving interrupt may be presented now or must wait, and it drives one interrupt line to the OS and one to the hypervisor.

Only two sets of signaling state exist. One is for OS and one is for the hypervisor, and each set is a current priority, a presented priority and a notification status. The two hypervisor rings share the hypervisor set. The notification status records which of the two rings presented the interrupt, and pull and withdraw actions use that field. When software raises its current priority above a presented interrupt, the interrupt is withdrawn. A group interrupt that is withdrawn or pulled away is handed back to the routing layer through a one-cycle redistribute strobe.

Control operations enter on a valid/ready command port. This port is always ready, and it takes priority over interrupt delivery. Interrupts enter on a second valid/ready port. Its ready signal is low whenever a command is offered in the same cycle, and a sender holds valid and its fields until ready is seen. Every accepted interrupt produces a result pulse one cycle later.

Top module: `tctx_presenter`

## Requirements
- R1: After reset, every current priority, presented priority, pending bitmap and status reads zero, both lines are low, and every arriving interrupt is precluded.
- R2: irq_ready is low in any cycle with cmd_valid high. Each accepted interrupt gives res_valid exactly one cycle later.
- R3: An interrupt of priority P on ring r is taken only when P is below 8 and strictly below the signaling presented priority of r. A taken interrupt sets that presented priority to P. A directed interrupt (level 0) with P below 8 always sets pending bit 7-P of ring r, whether it is taken or precluded.
- R4: POOL uses the hypervisor signaling set. Reading the POOL current priority, presented priority or status always gives zero, and a current-priority write to POOL changes nothing.
- R5: Status format: bits 5:0 hold the group level, and 0 means directed. For OS, bit 7 marks an exception. For the hypervisor, bits 7:6 hold the presenting ring: 01 for POOL and 10 for PHYS.
- R6: A current-priority write above 7 stores 0xFF.
- R7: A write that lowers the current priority to a value at or below the presented priority withdraws the interrupt. The status becomes 0 and the presented priority becomes the new value. Pending bits are kept.
- R8: If the withdrawn interrupt was a group interrupt, redist_valid pulses for one cycle with the ring recorded in the status.
- R9: If no exception is shown after any other current-priority write, the presented priority becomes the smallest of the bitmap priority, the group priority and the new current priority. The status is then raised if that value is below the current priority. For the hypervisor the bitmap priority merges POOL and PHYS, and PHYS wins ties.
- R10: The group backlog priority counts only while the ring's group size is nonzero. When it wins, the status carries the group size as the level.
- R11: A pull clears the ring's valid bit. It redistributes only if the status shows an active group exception recorded for that same ring. In that case the status is set to 0 and the presented priority is set to the current priority.
- R12: A line is high exactly when its status is nonzero and its presented priority is below its current priority. No line rises without a command or interrupt accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_op | input | 3 | 0 set current priority, 1 set group size, 2 set group priority, 3 push (valid=1), 4 pull |
| cmd_ring | input | 2 | 0 OS, 1 POOL, 2 PHYS; 3 is ignored |
| cmd_data | input | 8 | Command operand |
| irq_valid | input | 1 | Interrupt offered |
| irq_ready | output | 1 | Interrupt accepted |
| irq_ring | input | 2 | Target ring |
| irq_prio | input | 8 | Interrupt priority |
| irq_level | input | 6 | Group level, 0 for directed |
| res_valid | output | 1 | Result of an accepted interrupt |
| res_taken | output | 1 | 1 presented, 0 precluded |
| redist_valid | output | 1 | One-cycle redistribute strobe |
| redist_ring | output | 2 | Ring to redistribute for |
| os_line | output | 1 | OS interrupt line |
| hv_line | output | 1 | Hypervisor interrupt line |
| rd_ring | input | 2 | Read ring select |
| rd_sel | input | 3 | 0 bitmap, 1 current, 2 presented, 3 status, 4 group size, 5 group priority, 6 valid |
| rd_data | output | 8 | Combinational read data |

## Verification
The hardest case is a pull of the PHYS ring while the shared hypervisor status records a group interrupt that POOL presented. The pull must clear only PHYS's valid bit and must not redistribute, and a later pull of POOL must redistribute. The stimulus delivers a POOL group interrupt after the PHYS current priority has been opened to 0xFF. It then pulls both rings in turn and checks the strobe queue and the status after each pull. Withdrawing a group interrupt that the group backlog produced needs the group size and priority to be loaded and a recompute to be forced first. For that, the bench raises the current priority from a value at which the status is clear.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  localparam int PRIO_W = 8;
  localparam int LVL_W  = 6;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef logic [1:0] ring_t;
  localparam ring_t RING_OS   = 2'd0;
  localparam ring_t RING_POOL = 2'd1;
  localparam ring_t RING_PHYS = 2'd2;

  localparam logic [2:0] OP_CPPR  = 3'd0;
  localparam logic [2:0] OP_GSIZE = 3'd1;
  localparam logic [2:0] OP_GPRIO = 3'd2;
  localparam logic [2:0] OP_PUSH  = 3'd3;
  localparam logic [2:0] OP_PULL  = 3'd4;

  localparam logic [2:0] SEL_PEND  = 3'd0;
  localparam logic [2:0] SEL_CUR   = 3'd1;
  localparam logic [2:0] SEL_PRES  = 3'd2;
  localparam logic [2:0] SEL_STAT  = 3'd3;
  localparam logic [2:0] SEL_GSIZE = 3'd4;
  localparam logic [2:0] SEL_GPRIO = 3'd5;
  localparam logic [2:0] SEL_VLD   = 3'd6;

  // exception shown in a status byte; hyp selects the hypervisor format
  function automatic logic stat_exc(input logic hyp, input logic [7:0] st);
    if (hyp) return (st[7:6] == RING_POOL) || (st[7:6] == RING_PHYS);
    return st[7];
  endfunction

  function automatic logic stat_grp(input logic hyp, input logic [7:0] st);
    return stat_exc(hyp, st) && (st[LVL_W-1:0] != '0);
  endfunction

  function automatic ring_t stat_ring(input logic hyp, input logic [7:0] st);
    if (hyp) return st[7:6];
    return RING_OS;
  endfunction

  function automatic logic [7:0] make_stat(input logic hyp, input ring_t who,
                                           input logic [LVL_W-1:0] lvl);
    if (hyp) return {who, lvl};
    return {2'b10, lvl};
  endfunction
endpackage

// File: rtl/tctx_prio_enc.sv
module tctx_prio_enc #(
  parameter int NPRIO = 8,
  parameter int PW    = 8
) (
  input  logic [NPRIO-1:0] pend,
  output logic [PW-1:0]    prio
);
  // bit NPRIO-1 stands for priority 0; lowest set priority wins
  always_comb begin
    prio = '1;
    for (int p = NPRIO - 1; p >= 0; p--) begin
      if (pend[NPRIO-1-p]) prio = PW'(p);
    end
  end
endmodule

// File: rtl/tctx_recalc.sv
module tctx_recalc
  import tctx_pkg::*;
#(
  parameter bit IS_HYP = 1'b0
) (
  input  logic [PRIO_W-1:0] own_pend_prio,
  input  logic [PRIO_W-1:0] pool_pend_prio,
  input  logic [7:0]        gsize,
  input  logic [PRIO_W-1:0] gprio,
  input  logic [PRIO_W-1:0] new_cur,
  output logic [PRIO_W-1:0] pres_o,
  output logic [7:0]        stat_o
);
  localparam ring_t OWN_RING = IS_HYP ? RING_PHYS : RING_OS;

  logic [PRIO_W-1:0] pend_best, grp_eff, best;
  ring_t             pend_who, who;
  logic [LVL_W-1:0]  lvl;

  always_comb begin
    if (IS_HYP && (pool_pend_prio < own_pend_prio)) begin
      pend_best = pool_pend_prio;
      pend_who  = RING_POOL;
    end else begin
      pend_best = own_pend_prio;
      pend_who  = OWN_RING;
    end
    grp_eff = (gsize != 8'd0) ? gprio : PRIO_NONE;
    if (grp_eff < pend_best) begin
      best = grp_eff;
      who  = OWN_RING;
      lvl  = gsize[LVL_W-1:0];
    end else begin
      best = pend_best;
      who  = pend_who;
      lvl  = '0;
    end
    if (best < new_cur) begin
      pres_o = best;
      stat_o = make_stat(IS_HYP, who, lvl);
    end else begin
      pres_o = new_cur;
      stat_o = 8'd0;
    end
  end
endmodule

// File: rtl/tctx_line.sv
module tctx_line
  import tctx_pkg::*;
(
  input  logic [7:0]        stat,
  input  logic [PRIO_W-1:0] pres,
  input  logic [PRIO_W-1:0] cur,
  output logic              line
);
  assign line = (stat != 8'd0) && (pres < cur);
endmodule

// File: rtl/tctx_presenter.sv
module tctx_presenter
  import tctx_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [1:0]  cmd_ring,
  input  logic [7:0]  cmd_data,
  input  logic        irq_valid,
  output logic        irq_ready,
  input  logic [1:0]  irq_ring,
  input  logic [7:0]  irq_prio,
  input  logic [5:0]  irq_level,
  output logic        res_valid,
  output logic        res_taken,
  output logic        redist_valid,
  output logic [1:0]  redist_ring,
  output logic        os_line,
  output logic        hv_line,
  input  logic [1:0]  rd_ring,
  input  logic [2:0]  rd_sel,
  output logic [7:0]  rd_data
);
  localparam int NRING = 3;
  localparam int NSIG  = 2;
  localparam logic [PRIO_W-1:0] PRIO_MAX = PRIO_W'(NPRIO - 1);

  // per-ring state
  logic [NPRIO-1:0]  pend_q  [NRING];
  logic [7:0]        gsize_q [NRING];
  logic [PRIO_W-1:0] gprio_q [NRING];
  logic              vld_q   [NRING];
  // signaling state: slot 0 OS, slot 1 hypervisor (shared by POOL and PHYS)
  logic [PRIO_W-1:0] cur_q   [NSIG];
  logic [PRIO_W-1:0] pres_q  [NSIG];
  logic [7:0]        stat_q  [NSIG];

  logic [PRIO_W-1:0] pend_prio [NRING];
  logic [PRIO_W-1:0] rc_pres   [NSIG];
  logic [7:0]        rc_stat   [NSIG];
  logic              line_w    [NSIG];

  logic [PRIO_W-1:0] new_cur;
  logic              cmd_slot, irq_slot;
  logic              cmd_ring_ok, irq_ring_ok;
  logic              irq_fire;

  assign cmd_ready = 1'b1;
  assign irq_ready = !cmd_valid;
  assign irq_fire  = irq_valid && irq_ready;

  assign cmd_slot    = (cmd_ring != RING_OS);
  assign irq_slot    = (irq_ring != RING_OS);
  assign cmd_ring_ok = (cmd_ring != 2'd3);
  assign irq_ring_ok = (irq_ring != 2'd3);
  assign new_cur     = (cmd_data > PRIO_MAX) ? PRIO_NONE : cmd_data;

  genvar gr;
  generate
    for (gr = 0; gr < NRING; gr++) begin : g_enc
      tctx_prio_enc #(.NPRIO(NPRIO), .PW(PRIO_W)) u_enc (
        .pend (pend_q[gr]),
        .prio (pend_prio[gr])
      );
    end
    for (gr = 0; gr < NSIG; gr++) begin : g_sig
      localparam int OWN = (gr == 0) ? 0 : 2;
      tctx_recalc #(.IS_HYP(gr == 1)) u_rc (
        .own_pend_prio  (pend_prio[OWN]),
        .pool_pend_prio ((gr == 1) ? pend_prio[1] : PRIO_NONE),
        .gsize          (gsize_q[OWN]),
        .gprio          (gprio_q[OWN]),
        .new_cur        (new_cur),
        .pres_o         (rc_pres[gr]),
        .stat_o         (rc_stat[gr])
      );
      tctx_line u_line (
        .stat (stat_q[gr]),
        .pres (pres_q[gr]),
        .cur  (cur_q[gr]),
        .line (line_w[gr])
      );
    end
  endgenerate

  assign os_line = line_w[0];
  assign hv_line = line_w[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NRING; i++) begin
        pend_q[i]  <= '0;
        gsize_q[i] <= '0;
        gprio_q[i] <= '0;
        vld_q[i]   <= 1'b0;
      end
      for (int i = 0; i < NSIG; i++) begin
        cur_q[i]  <= '0;
        pres_q[i] <= '0;
        stat_q[i] <= '0;
      end
      redist_valid <= 1'b0;
      redist_ring  <= '0;
      res_valid    <= 1'b0;
      res_taken    <= 1'b0;
    end else begin
      redist_valid <= 1'b0;
      res_valid    <= 1'b0;
      res_taken    <= 1'b0;
      if (cmd_valid && cmd_ring_ok) begin
        case (cmd_op)
          OP_CPPR: begin
            if (cmd_ring != RING_POOL) begin
              cur_q[cmd_slot] <= new_cur;
              if ((new_cur < cur_q[cmd_slot]) && (new_cur <= pres_q[cmd_slot])) begin
                // withdraw the presented interrupt
                if (stat_grp(cmd_slot, stat_q[cmd_slot])) begin
                  redist_valid <= 1'b1;
                  redist_ring  <= stat_ring(cmd_slot, stat_q[cmd_slot]);
                end
                stat_q[cmd_slot] <= 8'd0;
                pres_q[cmd_slot] <= new_cur;
              end else if (!stat_exc(cmd_slot, stat_q[cmd_slot])) begin
                pres_q[cmd_slot] <= rc_pres[cmd_slot];
                stat_q[cmd_slot] <= rc_stat[cmd_slot];
              end
            end
          end
          OP_GSIZE: gsize_q[cmd_ring] <= cmd_data;
          OP_GPRIO: gprio_q[cmd_ring] <= cmd_data;
          OP_PUSH:  vld_q[cmd_ring]   <= 1'b1;
          OP_PULL: begin
            vld_q[cmd_ring] <= 1'b0;
            if (stat_grp(cmd_slot, stat_q[cmd_slot]) &&
                (stat_ring(cmd_slot, stat_q[cmd_slot]) == cmd_ring)) begin
              redist_valid     <= 1'b1;
              redist_ring      <= cmd_ring;
              stat_q[cmd_slot] <= 8'd0;
              pres_q[cmd_slot] <= cur_q[cmd_slot];
            end
          end
          default: ;
        endcase
      end else if (irq_fire) begin
        res_valid <= 1'b1;
        if (irq_ring_ok && (irq_prio <= PRIO_MAX)) begin
          if (irq_level == '0)
            pend_q[irq_ring][NPRIO-1-int'(irq_prio)] <= 1'b1;
          if (irq_prio < pres_q[irq_slot]) begin
            res_taken        <= 1'b1;
            pres_q[irq_slot] <= irq_prio;
            stat_q[irq_slot] <= make_stat(irq_slot, irq_ring, irq_level);
          end
        end
      end
    end
  end

  always_comb begin
    rd_data = 8'd0;
    if (rd_ring != 2'd3) begin
      case (rd_sel)
        SEL_PEND:  rd_data = 8'(pend_q[rd_ring]);
        SEL_CUR:   if (rd_ring != RING_POOL) rd_data = cur_q[rd_ring != RING_OS];
        SEL_PRES:  if (rd_ring != RING_POOL) rd_data = pres_q[rd_ring != RING_OS];
        SEL_STAT:  if (rd_ring != RING_POOL) rd_data = stat_q[rd_ring != RING_OS];
        SEL_GSIZE: rd_data = gsize_q[rd_ring];
        SEL_GPRIO: rd_data = gprio_q[rd_ring];
        SEL_VLD:   rd_data = {7'd0, vld_q[rd_ring]};
        default:   rd_data = 8'd0;
      endcase
    end
  end
endmodule

// File: rtl/tctx_presenter_chk.sv
module tctx_presenter_chk
  import tctx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [1:0] cmd_ring,
  input logic       irq_valid,
  input logic       irq_ready,
  input logic [7:0] irq_prio,
  input logic       res_valid,
  input logic       res_taken,
  input logic       redist_valid,
  input logic [1:0] redist_ring,
  input logic       os_line,
  input logic       hv_line,
  input logic [1:0] rd_ring,
  input logic [2:0] rd_sel,
  input logic [7:0] rd_data
);
  p_cmd_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !irq_ready);

  p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(irq_valid && irq_ready));

  p_taken_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |-> ($past(irq_prio) < 8'd8));

  p_pool_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_ring == RING_POOL) && ((rd_sel == SEL_CUR) || (rd_sel == SEL_PRES) ||
     (rd_sel == SEL_STAT))) |-> (rd_data == 8'd0));

  p_redist_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redist_valid |-> $past(cmd_valid && ((cmd_op == OP_CPPR) || (cmd_op == OP_PULL))));

  p_pull_same_ring_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (redist_valid && $past(cmd_op == OP_PULL)) |-> (redist_ring == $past(cmd_ring)));

  p_redist_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redist_valid |=> !redist_valid || $past(cmd_valid));

  p_hv_rise_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_line) |-> $past(cmd_valid || (irq_valid && irq_ready)));

  p_os_rise_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(os_line) |-> $past(cmd_valid || (irq_valid && irq_ready)));
endmodule

bind tctx_presenter tctx_presenter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_ring     (cmd_ring),
  .irq_valid    (irq_valid),
  .irq_ready    (irq_ready),
  .irq_prio     (irq_prio),
  .res_valid    (res_valid),
  .res_taken    (res_taken),
  .redist_valid (redist_valid),
  .redist_ring  (redist_ring),
  .os_line      (os_line),
  .hv_line      (hv_line),
  .rd_ring      (rd_ring),
  .rd_sel       (rd_sel),
  .rd_data      (rd_data)
);

// File: tb/tctx_presenter_tb.sv
module tctx_presenter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_ring = '0;
  logic [7:0] cmd_data = '0;
  logic       irq_valid = 1'b0;
  logic       irq_ready;
  logic [1:0] irq_ring = '0;
  logic [7:0] irq_prio = '0;
  logic [5:0] irq_level = '0;
  logic       res_valid, res_taken;
  logic       redist_valid;
  logic [1:0] redist_ring;
  logic       os_line, hv_line;
  logic [1:0] rd_ring = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [1:0] exp_redist[$];
  logic       exp_res[$];

  always #4 clk = ~clk;

  tctx_presenter u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_ring(cmd_ring), .cmd_data(cmd_data),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_ring(irq_ring),
    .irq_prio(irq_prio), .irq_level(irq_level),
    .res_valid(res_valid), .res_taken(res_taken),
    .redist_valid(redist_valid), .redist_ring(redist_ring),
    .os_line(os_line), .hv_line(hv_line),
    .rd_ring(rd_ring), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  localparam logic [1:0] OS = 2'd0, POOL = 2'd1, PHYS = 2'd2;
  localparam logic [2:0] CPPR = 3'd0, GSIZE = 3'd1, GPRIO = 3'd2, PUSH = 3'd3, PULL = 3'd4;
  localparam logic [2:0] PEND = 3'd0, CUR = 3'd1, PRES = 3'd2, STAT = 3'd3, VLD = 3'd6;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // monitor: compares strobes and results against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && redist_valid) begin
      total++;
      if (exp_redist.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected redistribute got=%0d exp=none", redist_ring);
      end else begin
        logic [1:0] e;
        e = exp_redist.pop_front();
        if (redist_ring !== e) begin
          bad++;
          $display("FAIL R8 redistribute ring got=%0d exp=%0d", redist_ring, e);
        end
      end
    end
    if (rst_n && res_valid) begin
      total++;
      if (exp_res.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected result got=%0b exp=none", res_taken);
      end else begin
        logic e;
        e = exp_res.pop_front();
        if (res_taken !== e) begin
          bad++;
          $display("FAIL R3 taken got=%0b exp=%0b", res_taken, e);
        end
      end
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] ring, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ring = ring; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_irq(input logic [1:0] ring, input logic [7:0] p,
                        input logic [5:0] lvl, input logic taken);
    exp_res.push_back(taken);
    @(negedge clk);
    irq_valid = 1'b1; irq_ring = ring; irq_prio = p; irq_level = lvl;
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] ring, input logic [2:0] sel,
                    input logic [7:0] exp);
    rd_ring = ring; rd_sel = sel;
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", OS, CUR, 8'h00);
    rd("R1", PHYS, PRES, 8'h00);
    rd("R1", PHYS, STAT, 8'h00);
    chk("R1 os_line", {7'd0, os_line}, 8'h00);
    chk("R1 hv_line", {7'd0, hv_line}, 8'h00);
    do_irq(OS, 8'd3, 6'd0, 1'b0);              // R1 precluded at reset
    rd("R3 pend", OS, PEND, 8'h10);

    // R2 command beats interrupt in the same cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = GSIZE; cmd_ring = OS; cmd_data = 8'h00;
    irq_valid = 1'b1;
    #1;
    chk("R2 ready", {7'd0, irq_ready}, 8'h00);
    @(negedge clk);
    cmd_valid = 1'b0; irq_valid = 1'b0;

    do_cmd(CPPR, OS, 8'd9);                     // R6 clamp
    rd("R6", OS, CUR, 8'hFF);
    rd("R9", OS, PRES, 8'h03);
    rd("R5", OS, STAT, 8'h80);
    chk("R12 os_line", {7'd0, os_line}, 8'h01);

    do_irq(OS, 8'd5, 6'd0, 1'b0);
    rd("R3 pend", OS, PEND, 8'h14);

    do_cmd(CPPR, OS, 8'd2);                     // R7 directed withdraw
    rd("R7", OS, PRES, 8'h02);
    rd("R7", OS, STAT, 8'h00);
    rd("R7", OS, PEND, 8'h14);
    chk("R7 os_line", {7'd0, os_line}, 8'h00);

    do_cmd(CPPR, OS, 8'd4);                     // R9 recompute
    rd("R9", OS, PRES, 8'h03);
    rd("R9", OS, STAT, 8'h80);
    chk("R9 os_line", {7'd0, os_line}, 8'h01);

    do_irq(OS, 8'd1, 6'd0, 1'b1);
    rd("R3", OS, PRES, 8'h01);
    rd("R3", OS, PEND, 8'h54);
    do_irq(OS, 8'd8, 6'd0, 1'b0);               // R3 out of range
    rd("R3", OS, PEND, 8'h54);

    do_cmd(CPPR, POOL, 8'd3);                   // R4 ignored
    rd("R4", POOL, CUR, 8'h00);
    rd("R4", PHYS, CUR, 8'h00);

    do_cmd(CPPR, PHYS, 8'hFF);
    rd("R9", PHYS, PRES, 8'hFF);
    rd("R9", PHYS, STAT, 8'h00);
    chk("R12 hv_line", {7'd0, hv_line}, 8'h00);

    do_irq(POOL, 8'd4, 6'd2, 1'b1);             // POOL group via shared set
    rd("R5", PHYS, STAT, 8'h42);
    rd("R4", POOL, STAT, 8'h00);
    rd("R4", PHYS, PRES, 8'h04);
    rd("R3 group no pend", POOL, PEND, 8'h00);
    chk("R12 hv_line", {7'd0, hv_line}, 8'h01);

    do_cmd(PUSH, POOL, 8'd0);
    do_cmd(PUSH, PHYS, 8'd0);
    do_cmd(PULL, PHYS, 8'd0);                   // R11 ring mismatch
    rd("R11", PHYS, VLD, 8'h00);
    rd("R11", POOL, VLD, 8'h01);
    rd("R11", PHYS, STAT, 8'h42);

    exp_redist.push_back(POOL);
    do_cmd(PULL, POOL, 8'd0);                   // R11 match
    rd("R11", POOL, VLD, 8'h00);
    rd("R11", PHYS, STAT, 8'h00);
    rd("R11", PHYS, PRES, 8'hFF);
    chk("R11 hv_line", {7'd0, hv_line}, 8'h00);

    do_irq(PHYS, 8'd3, 6'd1, 1'b1);
    rd("R5", PHYS, STAT, 8'h81);
    exp_redist.push_back(PHYS);
    do_cmd(CPPR, PHYS, 8'd2);                   // R8 group withdraw
    rd("R8", PHYS, STAT, 8'h00);
    rd("R8", PHYS, PRES, 8'h02);
    chk("R8 hv_line", {7'd0, hv_line}, 8'h00);

    do_irq(PHYS, 8'd4, 6'd0, 1'b0);
    rd("R3", PHYS, PEND, 8'h08);

    do_cmd(GSIZE, PHYS, 8'd1);
    do_cmd(GPRIO, PHYS, 8'd1);
    do_cmd(CPPR, PHYS, 8'd7);                   // R10 group wins
    rd("R10", PHYS, PRES, 8'h01);
    rd("R10", PHYS, STAT, 8'h81);

    exp_redist.push_back(PHYS);
    do_cmd(CPPR, PHYS, 8'd0);
    rd("R8", PHYS, PRES, 8'h00);

    do_cmd(GSIZE, PHYS, 8'd0);
    do_cmd(CPPR, PHYS, 8'd6);                   // R10 gated off
    rd("R10", PHYS, PRES, 8'h04);
    rd("R10", PHYS, STAT, 8'h80);

    do_irq(POOL, 8'd2, 6'd0, 1'b1);
    rd("R5", PHYS, STAT, 8'h40);
    rd("R3", POOL, PEND, 8'h20);
    chk("R12 hv_line", {7'd0, hv_line}, 8'h01);

    do_cmd(PULL, OS, 8'd0);                     // directed: no strobe
    rd("R11", OS, STAT, 8'h80);

    repeat (3) @(negedge clk);
    chk("R8 queue empty", 8'(exp_redist.size()), 8'h00);
    chk("R2 queue empty", 8'(exp_res.size()), 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule